// File: doc/BRIEF.md
# Twelve-Bit Pixel Packet Serializer

This block turns a stream of pixels, one per pixel period, into a serial bit stream. Each pixel becomes a 12-bit packet sent one bit per bit clock. The bit clock runs at twelve times the pixel rate. The pixel period is marked by `pix_tick`, a one-bit-clock strobe that is high once every twelve cycles. On the edge where the strobe is high, the block samples the pixel word, the line and frame qualifiers and the width mode. It then starts a new packet on the next cycle.

Every packet opens with a start bit of 1 and closes with a stop bit of 0. The ten bits in between carry one of two payloads. In wide mode they hold all ten pixel bits. In narrow mode they hold the eight most significant pixel bits, followed by the line-valid bit and then the frame-valid bit. Payload bits are sent least significant first. When strobes arrive every twelve cycles, packets follow each other with no gap. When no strobe arrives, the line rests at 0.

Top module: `ser_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first strobe, `ser_out` is 0.
- R2: The cycle after an edge where `pix_tick` is high, `ser_out` carries the start bit, which is 1. This is serial position 0.
- R3: Serial position 11, the twelfth bit of a packet, is the stop bit, which is 0.
- R4: When `mode_10b` is 1 at the sampling edge, positions 1 to 10 carry `pix_data[0]` up to `pix_data[9]`, in that order.
- R5: When `mode_10b` is 0 at the sampling edge, positions 1 to 8 carry `pix_data[2]` up to `pix_data[9]`, in that order.
- R6: In narrow mode, position 9 carries the sampled `line_valid` and position 10 carries the sampled `frame_valid`.
- R7: Changes to `pix_data`, `line_valid`, `frame_valid` or `mode_10b` on cycles where `pix_tick` is low do not alter the packet being sent.
- R8: With `pix_tick` high every twelfth cycle, the stop bit of one packet is followed directly by the start bit of the next. The width mode may differ from one packet to the next.
- R9: After the stop bit, if no new strobe has arrived, `ser_out` stays 0.
- R10: A strobe that arrives in the middle of a packet abandons the rest of that packet. The new packet starts at position 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve times the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_tick | input | 1 | Pixel-period strobe; high for one cycle per pixel |
| pix_data | input | 10 | Pixel word |
| line_valid | input | 1 | Line qualifier, sent in narrow mode |
| frame_valid | input | 1 | Frame qualifier, sent in narrow mode |
| mode_10b | input | 1 | 1 selects the wide payload, 0 the narrow payload |
| ser_out | output | 1 | Serial packet output |

## Verification
Position k of a packet is on `ser_out` during the k+1-th cycle after the sampling edge. The loading register adds one cycle, and each later bit comes one shift later. The bench drives inputs on falling edges and samples `ser_out` on falling edges. It reads position 0 at the first falling edge after the strobe edge and reads one further position at each falling edge after that. Right after each strobe edge the bench inverts every data and mode input. Any data or mode input sampled after the strobe edge therefore shows up as a mismatch. Checks on the idle level and on restart use the same cycle count.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned PIX_W_DEF    = 10;
  localparam int unsigned NARROW_W_DEF = 8;
  localparam int unsigned PKT_BITS_DEF = 12;

  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } ser_mode_e;
endpackage

// File: rtl/ser_pack.sv
module ser_pack
  import ser_pkg::*;
#(
  parameter int unsigned PIX_W    = PIX_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned PKT_BITS = PKT_BITS_DEF
) (
  input  logic [PIX_W-1:0]    pix,
  input  logic                lv,
  input  logic                fv,
  input  ser_mode_e           mode,
  output logic [PKT_BITS-1:0] pkt
);
  // Position 0 goes out first: start, payload LSB first, stop last.
  function automatic logic [PKT_BITS-1:0] build_packet(
    input logic [PIX_W-1:0] p,
    input logic             l,
    input logic             f,
    input ser_mode_e        m
  );
    logic [PKT_BITS-1:0] v;
    v = '0;
    v[0] = 1'b1;
    if (m == MODE_WIDE) begin
      v[PIX_W:1] = p;
    end else begin
      v[NARROW_W:1]   = p[PIX_W-1 -: NARROW_W];
      v[NARROW_W + 1] = l;
      v[NARROW_W + 2] = f;
    end
    v[PKT_BITS-1] = 1'b0;
    return v;
  endfunction

  assign pkt = build_packet(pix, lv, fv, mode);
endmodule

// File: rtl/ser_bitcnt.sv
module ser_bitcnt
  import ser_pkg::*;
#(
  parameter int unsigned PKT_BITS = PKT_BITS_DEF,
  localparam int unsigned CNT_W   = $clog2(PKT_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic [CNT_W-1:0] bit_idx
);
  localparam logic [CNT_W-1:0] IDLE = CNT_W'(PKT_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n)              bit_idx <= IDLE;
    else if (load)           bit_idx <= '0;
    else if (bit_idx != IDLE) bit_idx <= bit_idx + 1'b1;
  end
endmodule

// File: rtl/ser_shift.sv
module ser_shift
  import ser_pkg::*;
#(
  parameter int unsigned PKT_BITS = PKT_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [PKT_BITS-1:0] pkt,
  output logic                ser_out
);
  logic [PKT_BITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)    sh <= '0;
    else if (load) sh <= pkt;
    else           sh <= {1'b0, sh[PKT_BITS-1:1]};
  end

  assign ser_out = sh[0];
endmodule

// File: rtl/ser_top.sv
module ser_top
  import ser_pkg::*;
#(
  parameter int unsigned PIX_W    = PIX_W_DEF,
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned PKT_BITS = PKT_BITS_DEF,
  localparam int unsigned CNT_W   = $clog2(PKT_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_tick,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             line_valid,
  input  logic             frame_valid,
  input  logic             mode_10b,
  output logic             ser_out
);
  logic [PKT_BITS-1:0] pkt;
  logic [CNT_W-1:0]    bit_idx;  // position now on ser_out; PKT_BITS = idle
  ser_mode_e           mode;

  assign mode = ser_mode_e'(mode_10b);

  ser_pack #(.PIX_W(PIX_W), .NARROW_W(NARROW_W), .PKT_BITS(PKT_BITS)) u_pack (
    .pix (pix_data),
    .lv  (line_valid),
    .fv  (frame_valid),
    .mode(mode),
    .pkt (pkt)
  );

  ser_bitcnt #(.PKT_BITS(PKT_BITS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pix_tick),
    .bit_idx(bit_idx)
  );

  ser_shift #(.PKT_BITS(PKT_BITS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (pix_tick),
    .pkt    (pkt),
    .ser_out(ser_out)
  );
endmodule

// File: rtl/ser_chk.sv
module ser_chk
  import ser_pkg::*;
#(
  parameter int unsigned NARROW_W = NARROW_W_DEF,
  parameter int unsigned PKT_BITS = PKT_BITS_DEF,
  localparam int unsigned CNT_W   = $clog2(PKT_BITS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_tick,
  input logic             line_valid,
  input logic             frame_valid,
  input logic             mode_10b,
  input logic [CNT_W-1:0] bit_idx,
  input logic             ser_out
);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(PKT_BITS - 1);
  localparam logic [CNT_W-1:0] IDLE   = CNT_W'(PKT_BITS);
  localparam logic [CNT_W-1:0] LV_POS = CNT_W'(NARROW_W + 1);
  localparam logic [CNT_W-1:0] FV_POS = CNT_W'(NARROW_W + 2);

  logic cap_lv, cap_fv, cap_wide;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_lv <= 1'b0; cap_fv <= 1'b0; cap_wide <= 1'b1;
    end else if (pix_tick) begin
      cap_lv <= line_valid; cap_fv <= frame_valid; cap_wide <= mode_10b;
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) !rst_n |=> !ser_out);
  a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick |=> ser_out);
  a_r10_restart_pos: assert property (@(posedge clk) disable iff (!rst_n)
    pix_tick |=> bit_idx == '0);
  a_r3_stop_low: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx == LAST |-> !ser_out);
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx == IDLE |-> !ser_out);
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_tick && bit_idx < LAST) |=> bit_idx == $past(bit_idx) + 1'b1);
  a_r6_lv_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == LV_POS && !cap_wide) |-> ser_out == cap_lv);
  a_r6_fv_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_idx == FV_POS && !cap_wide) |-> ser_out == cap_fv);
endmodule

bind ser_top ser_chk #(.NARROW_W(NARROW_W), .PKT_BITS(PKT_BITS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_tick   (pix_tick),
  .line_valid (line_valid),
  .frame_valid(frame_valid),
  .mode_10b   (mode_10b),
  .bit_idx    (bit_idx),
  .ser_out    (ser_out)
);

// File: tb/tb_ser_top.sv
module tb_ser_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_tick = 1'b0;
  logic [9:0] pix_data = '0;
  logic       line_valid = 1'b0;
  logic       frame_valid = 1'b0;
  logic       mode_10b = 1'b0;
  logic       ser_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ser_top dut (
    .clk(clk), .rst_n(rst_n), .pix_tick(pix_tick), .pix_data(pix_data),
    .line_valid(line_valid), .frame_valid(frame_valid),
    .mode_10b(mode_10b), .ser_out(ser_out)
  );

  // {mode, fv, lv, pix}
  localparam logic [12:0] VEC [8] = '{
    {1'b1, 1'b0, 1'b0, 10'h3FF}, {1'b1, 1'b0, 1'b0, 10'h000},
    {1'b1, 1'b1, 1'b1, 10'h2A5}, {1'b0, 1'b1, 1'b1, 10'h3FC},
    {1'b0, 1'b0, 1'b1, 10'h155}, {1'b0, 1'b1, 1'b0, 10'h0A3},
    {1'b0, 1'b0, 0'b0 == 0 ? 1'b0 : 1'b0, 10'h3FF}, {1'b1, 1'b1, 1'b0, 10'h001}
  };

  // Expected bit at each serial position, from the requirements.
  function automatic logic [11:0] expect_pkt(logic [9:0] px, logic l, logic f, logic m);
    logic [11:0] e;
    for (int i = 0; i < 12; i++) begin
      if (i == 0)       e[i] = 1'b1;
      else if (i == 11) e[i] = 1'b0;
      else if (m)       e[i] = px[i-1];
      else if (i <= 8)  e[i] = px[i+1];
      else if (i == 9)  e[i] = l;
      else              e[i] = f;
    end
    return e;
  endfunction

  task automatic check(string req, logic [11:0] got, logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Strobe one pixel, then scramble every input (R7).
  task automatic strobe(logic [9:0] px, logic l, logic f, logic m);
    pix_data = px; line_valid = l; frame_valid = f; mode_10b = m;
    pix_tick = 1'b1;
    @(negedge clk);
    pix_tick = 1'b0;
    pix_data = ~px; line_valid = ~l; frame_valid = ~f; mode_10b = ~m;
  endtask

  task automatic grab(int n, output logic [11:0] got);
    got = '0;
    got[0] = ser_out;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      got[i] = ser_out;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    logic [11:0] got;
    logic [11:0] idle;
    @(negedge clk);
    check("R1 in reset", {11'd0, ser_out}, 12'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {11'd0, ser_out}, 12'd0);

    // Table: back-to-back packets, mode changing per packet (R4, R5, R6, R7, R8).
    for (int v = 0; v < 8; v++) begin
      strobe(VEC[v][9:0], VEC[v][10], VEC[v][11], VEC[v][12]);
      grab(12, got);
      check(VEC[v][12] ? "R2/R3/R4/R7/R8 wide" : "R2/R3/R5/R6/R7/R8 narrow",
            got, expect_pkt(VEC[v][9:0], VEC[v][10], VEC[v][11], VEC[v][12]));
    end

    // R9: no strobe after the stop bit keeps the line low.
    idle = '0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      idle[i] = ser_out;
    end
    check("R9 idle low", idle, 12'd0);

    // R10: strobe mid-packet restarts at position 0.
    strobe(10'h3FF, 1'b1, 1'b1, 1'b1);
    grab(5, got);
    strobe(10'h0F0, 1'b1, 1'b0, 1'b0);
    grab(12, got);
    check("R10 restart narrow", got, expect_pkt(10'h0F0, 1'b1, 1'b0, 1'b0));
    strobe(10'h000, 1'b0, 1'b0, 1'b0);
    grab(3, got);
    strobe(10'h2C3, 1'b0, 1'b0, 1'b1);
    grab(12, got);
    check("R10 restart wide", got, expect_pkt(10'h2C3, 1'b0, 1'b0, 1'b1));

    // R6: qualifiers alone, payload zero.
    strobe(10'h000, 1'b1, 1'b0, 1'b0);
    grab(12, got);
    check("R6 lv only", got, expect_pkt(10'h000, 1'b1, 1'b0, 1'b0));
    strobe(10'h000, 1'b0, 1'b1, 1'b0);
    grab(12, got);
    check("R6 fv only", got, expect_pkt(10'h000, 1'b0, 1'b1, 1'b0));
    @(negedge clk);
    check("R9 after packet", {11'd0, ser_out}, 12'd0);

    // R1: reset mid-packet clears the line.
    strobe(10'h3FF, 1'b1, 1'b1, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset mid-packet", {11'd0, ser_out}, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule